// File: doc/BRIEF.md
# Transport Header Anomaly Classifier

This block examines the transport-layer header of one received packet per accepted cycle and reports a single 4-bit anomaly code. An upstream parser supplies the fields already pulled out of the byte stream. These are: whether the packet is TCP or UDP, both port numbers, the TCP flag byte, the length carried in the transport header, the payload length implied by the IP header, how many transport bytes actually arrived, and a one-bit checksum verdict.

Several anomalies can be present at once. A fixed priority picks the one that is reported. A header that is too short to trust wins over every other check. After it come the length disagreement, the checksum, a zero port number and, for TCP only, six illegal flag combinations. The result is registered and appears one cycle after the input strobe. There is no back-pressure, so a new packet may be offered on every cycle.

Top module: `l4_anomaly_classifier`

## Requirements
- R1: While reset is asserted and on the first cycle after it, outValid is 0 and outCode is 0.
- R2: outValid is high exactly in the cycle after a cycle with inValid high. When inValid is low, outCode keeps its previous value on the next cycle.
- R3: Code 1 is reported when inBytesAvail is below the header size: 20 bytes for TCP, 8 for UDP. It overrides every other condition, because the remaining fields are not trusted.
- R4: Code 3 is reported when inL4Len differs from inIpPayLen. It ranks above the checksum check.
- R5: Code 2 is reported when inCksumOk is 0 and no check of higher rank matched.
- R6: Code 4 is reported when inSrcPort or inDstPort is zero and no check of higher rank matched.
- R7: The TCP flag byte uses bit 0 = FIN, 1 = SYN, 2 = RST, 5 = URG. Code 8 is reported when the byte equals exactly 0x01 (FIN alone).
- R8: For TCP, code 9 is reported when the flag byte is 0x00.
- R9: For TCP, code 10 is reported when FIN and RST are both set, whatever the other bits are.
- R10: For TCP, SYN+URG gives 11, SYN+RST gives 12 and SYN+FIN gives 13, whatever the other bits are. When more than one of these matches, the lowest code wins.
- R11: When inIsTcp is 0, the flag byte is ignored and only codes 0 to 4 can appear.
- R12: A packet that passes every check gives code 0. Codes 5, 6, 7 and anything above 13 are never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Header fields are valid this cycle |
| inIsTcp | input | 1 | 1 = TCP, 0 = UDP |
| inSrcPort | input | 16 | Source port |
| inDstPort | input | 16 | Destination port |
| inTcpFlags | input | 8 | TCP flag byte |
| inL4Len | input | 16 | Length carried in the transport header |
| inIpPayLen | input | 16 | Payload length implied by the IP header |
| inBytesAvail | input | 16 | Transport bytes actually received |
| inCksumOk | input | 1 | Checksum verdict from upstream |
| outValid | output | 1 | Code valid strobe |
| outCode | output | 4 | Anomaly code |

## Verification
The assertions check on every cycle the rules that need no ranking: the one-cycle strobe latency, that the code holds between packets, that a short header always yields code 1, that UDP stays within codes 0 to 4, and that the reserved codes never appear. Only the bench's scenarios can show the full priority ordering. That includes the cases where several anomalies overlap, such as a length mismatch together with a bad checksum, flag bytes where two SYN combinations collide, and the exact header-size boundaries of 19/20 and 7/8 bytes. These scenarios are compared against an independent reference model on every clock.

// File: rtl/l4c_pkg.sv
package l4c_pkg;

  localparam int CODE_W  = 4;
  localparam int NUM_CHK = 10;

  // TCP flag byte bit positions
  localparam int FIN_BIT = 0;
  localparam int SYN_BIT = 1;
  localparam int RST_BIT = 2;
  localparam int URG_BIT = 5;

  typedef enum logic [CODE_W-1:0] {
    CODE_NONE    = 4'd0,
    CODE_SHORT   = 4'd1,
    CODE_CKSUM   = 4'd2,
    CODE_LEN     = 4'd3,
    CODE_PORT    = 4'd4,
    CODE_FINONLY = 4'd8,
    CODE_NOFLAG  = 4'd9,
    CODE_FINRST  = 4'd10,
    CODE_SYNURG  = 4'd11,
    CODE_SYNRST  = 4'd12,
    CODE_SYNFIN  = 4'd13
  } l4Code_e;

  // Check indices, in priority order (index 0 wins)
  localparam int IX_SHORT   = 0;
  localparam int IX_LEN     = 1;
  localparam int IX_CKSUM   = 2;
  localparam int IX_PORT    = 3;
  localparam int IX_FINONLY = 4;
  localparam int IX_NOFLAG  = 5;
  localparam int IX_FINRST  = 6;
  localparam int IX_SYNURG  = 7;
  localparam int IX_SYNRST  = 8;
  localparam int IX_SYNFIN  = 9;

  typedef struct packed {
    logic               load;
    logic [NUM_CHK-1:0] pick;
  } l4Strobe_t;

  function automatic l4Code_e codeOf(input int idx);
    case (idx)
      IX_SHORT:   return CODE_SHORT;
      IX_LEN:     return CODE_LEN;
      IX_CKSUM:   return CODE_CKSUM;
      IX_PORT:    return CODE_PORT;
      IX_FINONLY: return CODE_FINONLY;
      IX_NOFLAG:  return CODE_NOFLAG;
      IX_FINRST:  return CODE_FINRST;
      IX_SYNURG:  return CODE_SYNURG;
      IX_SYNRST:  return CODE_SYNRST;
      IX_SYNFIN:  return CODE_SYNFIN;
      default:    return CODE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/l4c_control.sv
module l4c_control
  import l4c_pkg::*;
(
  input  logic               inValid,
  input  logic [NUM_CHK-1:0] hits,
  output l4Strobe_t          strobe
);

  // Fixed priority: the lowest index that matched is the one reported.
  always_comb begin
    logic found;
    found       = 1'b0;
    strobe.load = inValid;
    strobe.pick = '0;
    for (int i = 0; i < NUM_CHK; i++) begin
      if (hits[i] && !found) begin
        strobe.pick[i] = 1'b1;
        found          = 1'b1;
      end
    end
  end

endmodule

// File: rtl/l4c_datapath.sv
module l4c_datapath
  import l4c_pkg::*;
#(
  parameter int PORT_W   = 16,
  parameter int LEN_W    = 16,
  parameter int TCP_HDR  = 20,
  parameter int UDP_HDR  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               isTcp,
  input  logic [PORT_W-1:0]  srcPort,
  input  logic [PORT_W-1:0]  dstPort,
  input  logic [7:0]         tcpFlags,
  input  logic [LEN_W-1:0]   l4Len,
  input  logic [LEN_W-1:0]   ipPayLen,
  input  logic [LEN_W-1:0]   bytesAvail,
  input  logic               cksumOk,
  input  l4Strobe_t          strobe,
  output logic [NUM_CHK-1:0] hits,
  output logic               outValid,
  output logic [CODE_W-1:0]  outCode
);

  localparam logic [LEN_W-1:0] TCP_MIN = LEN_W'(TCP_HDR);
  localparam logic [LEN_W-1:0] UDP_MIN = LEN_W'(UDP_HDR);

  logic short_, trusted, tcpOk;
  logic fin, syn, rst, urg;

  assign short_  = bytesAvail < (isTcp ? TCP_MIN : UDP_MIN);
  assign trusted = !short_;
  assign tcpOk   = trusted && isTcp;
  assign fin     = tcpFlags[FIN_BIT];
  assign syn     = tcpFlags[SYN_BIT];
  assign rst     = tcpFlags[RST_BIT];
  assign urg     = tcpFlags[URG_BIT];

  // Condition vector; fields past the available bytes are masked.
  always_comb begin
    hits              = '0;
    hits[IX_SHORT]    = short_;
    hits[IX_LEN]      = trusted && (l4Len != ipPayLen);
    hits[IX_CKSUM]    = trusted && !cksumOk;
    hits[IX_PORT]     = trusted && ((srcPort == '0) || (dstPort == '0));
    hits[IX_FINONLY]  = tcpOk && (tcpFlags == 8'h01);
    hits[IX_NOFLAG]   = tcpOk && (tcpFlags == 8'h00);
    hits[IX_FINRST]   = tcpOk && fin && rst;
    hits[IX_SYNURG]   = tcpOk && syn && urg;
    hits[IX_SYNRST]   = tcpOk && syn && rst;
    hits[IX_SYNFIN]   = tcpOk && syn && fin;
  end

  logic [CODE_W-1:0] nextCode;
  always_comb begin
    nextCode = CODE_NONE;
    for (int i = 0; i < NUM_CHK; i++)
      if (strobe.pick[i]) nextCode = codeOf(i);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outCode  <= CODE_NONE;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) outCode <= nextCode;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outValid); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> (!outValid && $stable(outCode))); // R2
  AST_SHORT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && short_) |=> (outCode == CODE_SHORT)); // R3
  AST_UDP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !isTcp) |=> (outCode <= CODE_PORT)); // R11
  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    !((outCode >= 4'd5 && outCode <= 4'd7) || outCode > 4'd13)); // R12

endmodule

// File: rtl/l4_anomaly_classifier.sv
module l4_anomaly_classifier
  import l4c_pkg::*;
#(
  parameter int PORT_W  = 16,
  parameter int LEN_W   = 16,
  parameter int TCP_HDR = 20,
  parameter int UDP_HDR = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inIsTcp,
  input  logic [PORT_W-1:0] inSrcPort,
  input  logic [PORT_W-1:0] inDstPort,
  input  logic [7:0]        inTcpFlags,
  input  logic [LEN_W-1:0]  inL4Len,
  input  logic [LEN_W-1:0]  inIpPayLen,
  input  logic [LEN_W-1:0]  inBytesAvail,
  input  logic              inCksumOk,
  output logic              outValid,
  output logic [3:0]        outCode
);

  l4Strobe_t          strobe;
  logic [NUM_CHK-1:0] hits;

  l4c_control uCtrl (
    .inValid (inValid),
    .hits    (hits),
    .strobe  (strobe)
  );

  l4c_datapath #(
    .PORT_W  (PORT_W),
    .LEN_W   (LEN_W),
    .TCP_HDR (TCP_HDR),
    .UDP_HDR (UDP_HDR)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .isTcp      (inIsTcp),
    .srcPort    (inSrcPort),
    .dstPort    (inDstPort),
    .tcpFlags   (inTcpFlags),
    .l4Len      (inL4Len),
    .ipPayLen   (inIpPayLen),
    .bytesAvail (inBytesAvail),
    .cksumOk    (inCksumOk),
    .strobe     (strobe),
    .hits       (hits),
    .outValid   (outValid),
    .outCode    (outCode)
  );

endmodule

// File: tb/tb_l4_anomaly_classifier.sv
module tb_l4_anomaly_classifier;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inIsTcp = 1'b0;
  logic [15:0] inSrcPort = '0, inDstPort = '0;
  logic [7:0]  inTcpFlags = '0;
  logic [15:0] inL4Len = '0, inIpPayLen = '0, inBytesAvail = '0;
  logic        inCksumOk = 1'b0;
  logic        outValid;
  logic [3:0]  outCode;

  int total = 0, bad = 0, cycles = 0;
  bit checking = 0, finished = 0;

  always #10 clk = ~clk; // 50 MHz

  l4_anomaly_classifier dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inIsTcp(inIsTcp),
    .inSrcPort(inSrcPort), .inDstPort(inDstPort), .inTcpFlags(inTcpFlags),
    .inL4Len(inL4Len), .inIpPayLen(inIpPayLen), .inBytesAvail(inBytesAvail),
    .inCksumOk(inCksumOk), .outValid(outValid), .outCode(outCode)
  );

  // Reference: straight-line evaluation of the requirement list
  function automatic int refCode(bit tcp, int src, int dst, int fl,
                                 int l4, int ip, int av, bit ck);
    bit fin = fl[0], syn = fl[1], rst = fl[2], urg = fl[5];
    if (av < (tcp ? 20 : 8)) return 1;
    if (l4 != ip)            return 3;
    if (!ck)                 return 2;
    if (src == 0 || dst == 0) return 4;
    if (!tcp)                return 0;
    if (fl == 1)             return 8;
    if (fl == 0)             return 9;
    if (fin && rst)          return 10;
    if (syn && urg)          return 11;
    if (syn && rst)          return 12;
    if (syn && fin)          return 13;
    return 0;
  endfunction

  function automatic string tagOf(int c, bit tcp);
    case (c)
      1: return "R3";
      3: return "R4";
      2: return "R5";
      4: return "R6";
      8: return "R7";
      9: return "R8";
      10: return "R9";
      11, 12, 13: return "R10";
      default: return tcp ? "R12" : "R11";
    endcase
  endfunction

  int    expValid = 0, expCode = 0;
  string expTag = "R1";

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expValid <= 0; expCode <= 0; expTag <= "R1";
    end else begin
      expValid <= int'(inValid);
      if (inValid) begin
        expCode <= refCode(inIsTcp, int'(inSrcPort), int'(inDstPort), int'(inTcpFlags),
                           int'(inL4Len), int'(inIpPayLen), int'(inBytesAvail), inCksumOk);
        expTag  <= tagOf(refCode(inIsTcp, int'(inSrcPort), int'(inDstPort), int'(inTcpFlags),
                           int'(inL4Len), int'(inIpPayLen), int'(inBytesAvail), inCksumOk), inIsTcp);
      end else begin
        expTag  <= "R2";
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (checking) begin
      check("R2", "outValid", int'(outValid), expValid);
      check(expTag, "outCode", int'(outCode), expCode);
    end
  end

  task automatic send(bit tcp, int src, int dst, int fl, int l4, int ip, int av, bit ck);
    @(negedge clk);
    inValid = 1'b1; inIsTcp = tcp;
    inSrcPort = 16'(src); inDstPort = 16'(dst); inTcpFlags = 8'(fl);
    inL4Len = 16'(l4); inIpPayLen = 16'(ip); inBytesAvail = 16'(av); inCksumOk = ck;
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0; inIsTcp = 1'($urandom);
    inSrcPort = 16'($urandom); inDstPort = 16'($urandom); inTcpFlags = 8'($urandom);
    inL4Len = 16'($urandom); inIpPayLen = 16'($urandom);
    inBytesAvail = 16'($urandom); inCksumOk = 1'($urandom);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "outValid in reset", int'(outValid), 0);
    check("R1", "outCode in reset", int'(outCode), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "outValid after reset", int'(outValid), 0);
    check("R1", "outCode after reset", int'(outCode), 0);
    checking = 1;

    send(1, 80, 443, 8'h10, 40, 40, 40, 1);   // clean ACK -> 0 (R12)
    send(1, 0, 0, 8'h03, 5, 9, 19, 0);        // R3 TCP 19 bytes, all bad
    send(1, 80, 443, 8'h10, 20, 20, 20, 1);   // R3 boundary 20 clean
    send(0, 53, 53, 8'h00, 8, 9, 7, 0);       // R3 UDP 7 bytes
    send(0, 53, 53, 8'h00, 8, 8, 8, 1);       // R11 UDP, flags 0 ignored
    send(0, 53, 53, 8'h01, 8, 8, 8, 1);       // R11 UDP, FIN ignored
    idle(); idle();                           // R2 hold
    send(1, 0, 1, 8'h00, 30, 31, 40, 0);      // R4 mismatch over cksum
    send(1, 0, 1, 8'h00, 30, 30, 40, 0);      // R5 cksum over port
    send(1, 0, 1, 8'h01, 30, 30, 40, 1);      // R6 zero src
    send(0, 7, 0, 8'h00, 30, 30, 40, 1);      // R6 zero dst, UDP
    send(1, 1, 1, 8'h01, 30, 30, 40, 1);      // R7
    send(1, 1, 1, 8'h00, 30, 30, 40, 1);      // R8
    send(1, 1, 1, 8'h11, 30, 30, 40, 1);      // FIN+ACK legal -> 0
    send(1, 1, 1, 8'h05, 30, 30, 40, 1);      // R9
    send(1, 1, 1, 8'hFF, 30, 30, 40, 1);      // R9 beats SYN combos
    send(1, 1, 1, 8'h23, 30, 30, 40, 1);      // R10 SYN+URG+FIN -> 11
    send(1, 1, 1, 8'h22, 30, 30, 40, 1);      // R10 -> 11
    send(1, 1, 1, 8'h07 & 8'h06, 30, 30, 40, 1); // R10 SYN+RST -> 12
    send(1, 1, 1, 8'h03, 30, 30, 40, 1);      // R10 SYN+FIN -> 13
    idle();

    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 4) == 0) idle();
      else begin
        int l4v = $urandom_range(0, 60);
        send(1'($urandom),
             ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 65535),
             ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 65535),
             ($urandom_range(0, 1) == 0) ? $urandom_range(0, 7) | ($urandom_range(0, 1) << 5)
                                         : $urandom_range(0, 255),
             l4v,
             ($urandom_range(0, 7) == 0) ? $urandom_range(0, 60) : l4v,
             $urandom_range(0, 40),
             ($urandom_range(0, 7) != 0));
      end
    end
    idle(); idle();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule